// File: doc/BRIEF.md
# Subaddressed I2C Register Telegram Target

This block is an I2C target for a chip whose user registers are 16 bits wide and grouped into sections. After the device address, the controller sends one subaddress byte. That byte picks one of three targets: a single control register held inside the block, a demodulator bank, or a processing bank. For a bank access, two address bytes and then a 16-bit data word follow. Every word travels high byte first, and every byte travels MSB first. To read, the controller sends the subaddress and any address bytes, then a repeated start with the read device address, and then clocks two bytes back.

Toward the chip, the block drives a plain register-file port: a section code, a 16-bit address, write data and a one-cycle write strobe. It takes read data in return. The control register stays inside the block, and its top bit drives a chip-level reset output. Both bus lines are brought onto the system clock through a synchronizer. The block pulls SDA low through an open-drain enable and never stretches SCL.

Top module: `i2c_tg_slave`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `dev_reset` are all 0, and the control register holds 0x0000.
- R2: The block acknowledges a device write address only if it equals the base chosen by `addr_sel` (0 → 0x80, 1 → 0x84, 2 → 0x88, 3 → 0x80). The read address is the base plus one. Any other address is not acknowledged, and the block ignores the bus until the next stop.
- R3: Valid subaddresses are 0x00 (control), 0x10 (demodulator write), 0x11 (demodulator read), 0x12 (processing write) and 0x13 (processing read). Any other subaddress is not acknowledged, and the block ignores the rest of the telegram until a stop, acknowledging no further bytes.
- R4: A bank write (0x10 or 0x12, then address high, address low, data high, data low) gives exactly one `reg_we` pulse lasting one clock cycle. The pulse comes at the end of the acknowledge of the last data byte, with `reg_sect` = 1 for the demodulator or 2 for processing, `reg_addr` = the 16-bit address and `reg_wdata` = the 16-bit word.
- R5: A telegram that ends with a stop before its second data byte has been acknowledged produces no write strobe.
- R6: A control write (0x00, data high, data low) stores the word. `dev_reset` equals bit 15 of the stored word: writing 0x8000 sets it to 1 and writing 0x0000 clears it. A control write never pulses `reg_we`.
- R7: A bank read (0x11 or 0x13, address high, address low, repeated start, read address) returns the `reg_rdata` word for that section and address, high byte first and MSB first.
- R8: A control read (0x00, repeated start, read address) returns the stored control word.
- R9: When the controller does not acknowledge a returned byte, the block releases SDA. It stays released until a stop, after which the next telegram is served normally.
- R10: A read device address is not acknowledged unless, since the last stop, a read subaddress with its address bytes or the control subaddress has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| addr_sel | input | 2 | Selects the device address pair |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_sect | output | 2 | Section of the current access: 1 demodulator, 2 processing, 0 control |
| reg_addr | output | 16 | Register address inside the bank |
| reg_wdata | output | 16 | Word to be written |
| reg_we | output | 1 | One-cycle write strobe for bank writes |
| reg_rdata | input | 16 | Word returned for `reg_sect` and `reg_addr` |
| dev_reset | output | 1 | Chip reset, bit 15 of the control register |

## Verification
The bench runs full telegrams of every kind: bank writes to both sections, control writes that set and then clear the reset, bank reads in both sections, and control reads. These show that the subaddress picks the section and direction, and that both words are assembled high byte first. Further telegrams carry a wrong device address, an out-of-set subaddress, a read address with no prior read setup, and a stop that cuts a word in half. Each of these must be refused without a strobe, which separates the acknowledge decision from the write path. The last pattern, a read that the controller cuts short after one byte and that is followed by a normal write, shows that the block lets go of SDA and recovers cleanly after a stop.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        SECT_CTRL  = 2'd0,
        SECT_DEMOD = 2'd1,
        SECT_PROC  = 2'd2
    } sect_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } bus_st_e;

    typedef enum logic [2:0] {
        P_DEV,
        P_SUB,
        P_AHI,
        P_ALO,
        P_DHI,
        P_DLO,
        P_END
    } tg_pos_e;

    typedef struct packed {
        sect_e sect;
        logic  rd;
    } sub_t;

    function automatic logic [BYTE_W-1:0] dev_base(input logic [1:0] sel);
        case (sel)
            2'd1:    return 8'h84;
            2'd2:    return 8'h88;
            default: return 8'h80;
        endcase
    endfunction

    function automatic logic sub_valid(input logic [BYTE_W-1:0] s);
        return (s == 8'h00) || (s >= 8'h10 && s <= 8'h13);
    endfunction

    function automatic sub_t sub_decode(input logic [BYTE_W-1:0] s);
        sub_t r;
        r.rd = s[0];
        if (s == 8'h00)
            r.sect = SECT_CTRL;
        else if (s[1])
            r.sect = SECT_PROC;
        else
            r.sect = SECT_DEMOD;
        return r;
    endfunction

endpackage

// File: rtl/i2c_tg_bus_cond.sv
module i2c_tg_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_d;
    logic sda_d;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_q = scl_pipe[SYNC_STAGES-1];
    assign sda_q = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    // SDA may only change meaning while SCL is high on both samples
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/i2c_tg_ctrl_reg.sv
module i2c_tg_ctrl_reg
    import i2c_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              dev_reset
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    assign dev_reset = ctrl_q[WORD_W-1];

    // R6: the reset output follows the top bit of each control write
    a_r6_reset_tracks: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> dev_reset == $past(wr_data[WORD_W-1]));

endmodule

// File: rtl/i2c_tg_slave.sv
module i2c_tg_slave
    import i2c_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  addr_sel,
    output logic        sda_oe,
    output logic [1:0]  reg_sect,
    output logic [15:0] reg_addr,
    output logic [15:0] reg_wdata,
    output logic        reg_we,
    input  logic [15:0] reg_rdata,
    output logic        dev_reset
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    i2c_tg_bus_cond #(.SYNC_STAGES(2)) u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_st_e              st;
    tg_pos_e              pos;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]    shreg;
    sub_t                 sub_q;
    logic [WORD_W-1:0]    addr_q;
    logic [WORD_W-1:0]    wdata_q;
    logic [BYTE_W-1:0]    dhi_q;
    logic [BYTE_W-1:0]    tx_lo;
    logic                 armed, pend_we, tx_go, tx_idx, mack;
    logic                 sda_oe_q, reg_we_q, ctrl_we;
    logic [WORD_W-1:0]    ctrl_q;
    logic [WORD_W-1:0]    tx_word;
    logic [BYTE_W-1:0]    base;
    logic                 byte_ok;

    i2c_tg_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_we), .wr_data(wdata_q),
        .ctrl_q(ctrl_q), .dev_reset(dev_reset)
    );

    assign base    = dev_base(addr_sel);
    assign tx_word = (sub_q.sect == SECT_CTRL) ? ctrl_q : reg_rdata;

    // Acknowledge decision for the byte just shifted in
    always_comb begin
        case (pos)
            P_DEV:   byte_ok = (shreg == {base[7:1], 1'b0}) ||
                               ((shreg == {base[7:1], 1'b1}) && armed);
            P_SUB:   byte_ok = sub_valid(shreg);
            P_AHI, P_ALO, P_DHI, P_DLO: byte_ok = 1'b1;
            default: byte_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pos      <= P_DEV;
            bitcnt   <= '0;
            shreg    <= '0;
            sub_q    <= '{sect: SECT_CTRL, rd: 1'b0};
            addr_q   <= '0;
            wdata_q  <= '0;
            dhi_q    <= '0;
            tx_lo    <= '0;
            armed    <= 1'b0;
            pend_we  <= 1'b0;
            tx_go    <= 1'b0;
            tx_idx   <= 1'b0;
            mack     <= 1'b0;
            sda_oe_q <= 1'b0;
            reg_we_q <= 1'b0;
            ctrl_we  <= 1'b0;
        end else begin
            reg_we_q <= 1'b0;
            ctrl_we  <= 1'b0;
            if (stop_det) begin
                st       <= ST_IDLE;
                sda_oe_q <= 1'b0;
                armed    <= 1'b0;
                pend_we  <= 1'b0;
                tx_go    <= 1'b0;
            end else if (start_det && st != ST_WAIT) begin
                st       <= ST_RX;
                pos      <= P_DEV;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
                pend_we  <= 1'b0;
                tx_go    <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_q};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BIT_CNT_W'(BYTE_W)) begin
                            bitcnt <= '0;
                            if (byte_ok) begin
                                st       <= ST_RACK;
                                sda_oe_q <= 1'b1;
                                case (pos)
                                    P_DEV: begin
                                        if (shreg[0]) begin
                                            tx_go <= 1'b1;
                                            pos   <= P_END;
                                        end else begin
                                            pos <= P_SUB;
                                        end
                                    end
                                    P_SUB: begin
                                        sub_q <= sub_decode(shreg);
                                        armed <= (shreg == 8'h00);
                                        pos   <= (shreg == 8'h00) ? P_DHI : P_AHI;
                                    end
                                    P_AHI: begin
                                        addr_q[15:8] <= shreg;
                                        pos          <= P_ALO;
                                    end
                                    P_ALO: begin
                                        addr_q[7:0] <= shreg;
                                        if (sub_q.rd) begin
                                            armed <= 1'b1;
                                            pos   <= P_END;
                                        end else begin
                                            pos <= P_DHI;
                                        end
                                    end
                                    P_DHI: begin
                                        dhi_q <= shreg;
                                        pos   <= P_DLO;
                                    end
                                    P_DLO: begin
                                        wdata_q <= {dhi_q, shreg};
                                        pend_we <= 1'b1;
                                        pos     <= P_END;
                                    end
                                    default: pos <= P_END;
                                endcase
                            end else begin
                                st       <= ST_WAIT;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (tx_go) begin
                                tx_go    <= 1'b0;
                                shreg    <= tx_word[15:8];
                                tx_lo    <= tx_word[7:0];
                                tx_idx   <= 1'b0;
                                sda_oe_q <= ~tx_word[15];
                                st       <= ST_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                st       <= ST_RX;
                                if (pend_we) begin
                                    pend_we <= 1'b0;
                                    if (sub_q.sect == SECT_CTRL)
                                        ctrl_we <= 1'b1;
                                    else
                                        reg_we_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                sda_oe_q <= 1'b0;
                                bitcnt   <= '0;
                                st       <= ST_TACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~shreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (mack && !tx_idx) begin
                                shreg    <= tx_lo;
                                sda_oe_q <= ~tx_lo[BYTE_W-1];
                                tx_idx   <= 1'b1;
                                bitcnt   <= '0;
                                st       <= ST_TX;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = sda_oe_q;
    assign reg_we    = reg_we_q;
    assign reg_sect  = sub_q.sect;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;

    // R4: a strobe is a single-cycle pulse
    a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R4, R6: strobes only target a bank, never the control section
    a_r4_we_bank: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_sect == SECT_DEMOD || reg_sect == SECT_PROC));

    // R3: while ignoring the bus the line stays released
    a_r3_wait_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !sda_oe);

    // R2: the block only starts pulling SDA while SCL is low
    a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_q);

    // R9: a stop always returns to idle with SDA released
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE && !sda_oe));

endmodule

// File: tb/i2c_tg_slave_tb.sv
module i2c_tg_slave_tb;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic [1:0]  addr_sel = 2'd0;
    logic        sda_oe;
    logic [1:0]  reg_sect;
    logic [15:0] reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic        dev_reset;
    logic        sda_line;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    always_comb reg_rdata = reg_addr ^ ((reg_sect == 2'd2) ? 16'h5A00 : 16'h0C3C);

    i2c_tg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .addr_sel(addr_sel),
        .sda_oe(sda_oe), .reg_sect(reg_sect), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .dev_reset(dev_reset)
    );

    typedef struct {
        logic [1:0]  s;
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } wexp_t;

    wexp_t exq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every strobe must match the oldest expected write
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exq.size() == 0) begin
                chk(0, "R5 unexpected write strobe", {reg_sect, reg_addr[13:0], reg_wdata}, 32'h0);
            end else begin
                wexp_t e;
                e = exq.pop_front();
                chk(reg_sect == e.s && reg_addr == e.a && reg_wdata == e.d, e.tag,
                    {reg_sect, 14'h0, reg_wdata}, {e.s, 14'h0, e.d});
                chk(reg_addr == e.a, e.tag, {16'h0, reg_addr}, {16'h0, e.a});
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b1; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b0; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            scl = 1'b1;    wq(2 * Q);
            scl = 1'b0;    wq(Q);
        end
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_low = 1'b0; wq(Q);
            scl = 1'b1;   wq(Q);
            b = {b[6:0], sda_line};
            wq(Q);
            scl = 1'b0;   wq(Q);
        end
        m_low = give_ack; wq(Q);
        scl = 1'b1;       wq(2 * Q);
        scl = 1'b0;       wq(Q);
        m_low = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
        bit a;
        send_byte(b, a);
        chk(a == exp_ack, tag, {31'h0, a}, {31'h0, exp_ack});
    endtask

    task automatic wr_bank(input logic [7:0] dev, input logic [7:0] sub,
                           input logic [15:0] ad, input logic [15:0] dt, input string tag);
        wexp_t e;
        e.s = sub[1] ? 2'd2 : 2'd1; e.a = ad; e.d = dt; e.tag = tag;
        exq.push_back(e);
        i2c_start();
        send_chk(dev, 1, tag);
        send_chk(sub, 1, tag);
        send_chk(ad[15:8], 1, tag);
        send_chk(ad[7:0], 1, tag);
        send_chk(dt[15:8], 1, tag);
        send_chk(dt[7:0], 1, tag);
        i2c_stop();
    endtask

    task automatic wr_ctrl(input logic [15:0] dt, input string tag);
        i2c_start();
        send_chk(8'h80, 1, tag);
        send_chk(8'h00, 1, tag);
        send_chk(dt[15:8], 1, tag);
        send_chk(dt[7:0], 1, tag);
        i2c_stop();
    endtask

    task automatic rd_word(input logic [7:0] sub, input bit with_addr, input logic [15:0] ad,
                           input logic [15:0] exp, input string tag);
        logic [7:0] hi, lo;
        i2c_start();
        send_chk(8'h80, 1, tag);
        send_chk(sub, 1, tag);
        if (with_addr) begin
            send_chk(ad[15:8], 1, tag);
            send_chk(ad[7:0], 1, tag);
        end
        i2c_start();
        send_chk(8'h81, 1, tag);
        read_byte(1, hi);
        read_byte(0, lo);
        chk({hi, lo} == exp, tag, {16'h0, hi, lo}, {16'h0, exp});
        wq(Q);
        chk(sda_oe == 1'b0, "R9 released after controller NACK", {31'h0, sda_oe}, 32'h0);
        i2c_stop();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] hb;
        wq(5);
        rst = 1'b0;
        wq(3);
        // R1: reset state
        chk(sda_oe == 0, "R1 sda_oe after reset", {31'h0, sda_oe}, 0);
        chk(reg_we == 0, "R1 reg_we after reset", {31'h0, reg_we}, 0);
        chk(dev_reset == 0, "R1 dev_reset after reset", {31'h0, dev_reset}, 0);

        // R4: bank writes in both sections
        wr_bank(8'h80, 8'h10, 16'h0030, 16'h0001, "R4 demod write");
        wr_bank(8'h80, 8'h12, 16'h0008, 16'h0120, "R4 proc write");

        // R6: control register drives reset
        wr_ctrl(16'h8000, "R6 ctrl write 8000");
        wq(2);
        chk(dev_reset == 1, "R6 dev_reset set", {31'h0, dev_reset}, 1);
        wr_ctrl(16'h0000, "R6 ctrl write 0000");
        wq(2);
        chk(dev_reset == 0, "R6 dev_reset cleared", {31'h0, dev_reset}, 0);

        // R2: foreign address ignored until stop
        i2c_start();
        send_chk(8'h84, 0, "R2 foreign address nacked");
        send_chk(8'h10, 0, "R2 bytes after foreign address ignored");
        i2c_stop();

        // R2: alternate pair selected
        addr_sel = 2'd1;
        wr_bank(8'h84, 8'h12, 16'h0100, 16'hBEEF, "R2 alternate pair write");
        addr_sel = 2'd2;
        i2c_start();
        send_chk(8'h80, 0, "R2 base address refused when 0x88 selected");
        i2c_stop();
        addr_sel = 2'd0;

        // R3: out-of-set subaddresses
        i2c_start();
        send_chk(8'h80, 1, "R3 address before bad sub");
        send_chk(8'h20, 0, "R3 sub 0x20 nacked");
        send_chk(8'h00, 0, "R3 following byte ignored");
        i2c_stop();
        i2c_start();
        send_chk(8'h80, 1, "R3 address before sub 0x14");
        send_chk(8'h14, 0, "R3 sub 0x14 nacked");
        i2c_stop();

        // R5: stop inside the data word
        i2c_start();
        send_chk(8'h80, 1, "R5 partial telegram");
        send_chk(8'h10, 1, "R5 partial telegram");
        send_chk(8'h00, 1, "R5 partial telegram");
        send_chk(8'h40, 1, "R5 partial telegram");
        send_chk(8'h12, 1, "R5 partial telegram");
        i2c_stop();

        // R7: bank reads
        rd_word(8'h13, 1, 16'h1234, 16'h4834, "R7 proc read");
        rd_word(8'h11, 1, 16'h0200, 16'h0E3C, "R7 demod read");

        // R8: control read
        wr_ctrl(16'h1234, "R8 ctrl write before read");
        rd_word(8'h00, 0, 16'h0000, 16'h1234, "R8 ctrl read");

        // R10: read address without setup
        i2c_start();
        send_chk(8'h81, 0, "R10 read without setup nacked");
        i2c_stop();

        // R9: controller stops after one byte, then a normal write
        i2c_start();
        send_chk(8'h80, 1, "R9 setup");
        send_chk(8'h13, 1, "R9 setup");
        send_chk(8'h00, 1, "R9 setup");
        send_chk(8'h01, 1, "R9 setup");
        i2c_start();
        send_chk(8'h81, 1, "R9 read address");
        read_byte(0, hb);
        chk(hb == 8'h5A, "R9 high byte before early NACK", {24'h0, hb}, 32'h5A);
        wq(2 * Q);
        chk(sda_oe == 0, "R9 SDA released after early NACK", {31'h0, sda_oe}, 0);
        i2c_stop();
        wr_bank(8'h80, 8'h10, 16'hA5A5, 16'h0F0F, "R9 write after early NACK");

        wq(20);
        chk(exq.size() == 0, "R4 all expected strobes seen", exq.size(), 0);
        done = 1;
        finish_run();
    end

endmodule